// File: doc/BRIEF.md
# CPU reset and strap sequencer

This block produces the active-low reset for the processor from an asynchronous system reset. The processor reset follows the system reset down at once. After the system reset is released, the processor reset stays low for a fixed stretch, which is 1 ms by default. The stretch is counted in bus clocks, and its length comes from a clock-frequency parameter and a duration parameter.

The block also drives a bus-request strap line as a tristate pair: a data value and an output enable. The processor reads a configuration from this line when its reset is released. So the line is held low for the whole reset and for a short window after the release. Then the driver lets go of the line.

After that window the same line carries one thing only. It gives the processor's front-side-bus input buffers an early signal that bus activity is about to start, taken from a strobe input. If the system reset is asserted again at any point, the whole sequence starts over.

Top module: `cpurst_seq`

## Requirements
- R1: While `sys_rst_n` is low, `cpu_rst_n` is 0, `strap_oe` is 1 and `strap_o` is 0. These values appear as soon as `sys_rst_n` falls, without waiting for a clock edge.
- R2: The release of `sys_rst_n` passes through a chain of SYNC_STAGES flops. Number the first rising edge after the release as edge 1. `cpu_rst_n` goes high on edge SYNC_STAGES+1+STRETCH_CYC, and it stays low before that edge. STRETCH_CYC equals (CLK_HZ/1_000_000)*STRETCH_US, which gives 1 ms by default.
- R3: While `cpu_rst_n` is low, the strap is driven low (`strap_oe`=1, `strap_o`=0). Elaboration rejects any STRETCH_CYC below 4, so the strap is always low for at least 4 clocks before the release.
- R4: After `cpu_rst_n` rises, the strap stays driven low for exactly HOLD_CYC more cycles. Elaboration rejects any HOLD_CYC outside 2 to 20. The default is 4.
- R5: Once the hold window has ended, `strap_o` is 0 and `strap_oe` follows `early_ind` in the same cycle. The line is driven low as the early hint while `early_ind` is 1, and it is tristated while `early_ind` is 0.
- R6: `early_ind` has no effect on `strap_oe` or `strap_o` before the hold window has ended.
- R7: Asserting `sys_rst_n` again during the stretch, the hold window or normal operation restarts the full sequence. The R2 and R4 timing is measured again from the new release.
- R8: Once `cpu_rst_n` is high, it falls only when `sys_rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| early_ind | input | 1 | Strobe that requests the early-activity hint in normal operation |
| cpu_rst_n | output | 1 | Active-low processor reset |
| strap_o | output | 1 | Value for the strap line driver (always low) |
| strap_oe | output | 1 | Output enable for the strap line driver; 0 tristates the line |

## Verification
Assertion of the system reset takes effect with zero delay. The bench checks it 1 ns after the falling edge it drives, before any clock edge.

All other results are counted in rising edges from the release edge. The processor reset is due after SYNC_STAGES+1+STRETCH_CYC edges, and the end of the strap hold after HOLD_CYC more. In normal operation `early_ind` reaches `strap_oe` in the same cycle.

The bench drives each input on a falling edge. On that same edge it queues the output value due after the next rising edge, and it compares that value 5 ns after the rising edge. This way every sample falls in the right cycle and away from any edge.

// File: rtl/cpurst_pkg.sv
`timescale 1ns/1ps
package cpurst_pkg;

   // Encoding: bit 1 set means the processor reset is released.
   typedef enum logic [1:0] {
      SEQ_RST     = 2'b00,
      SEQ_STRETCH = 2'b01,
      SEQ_HOLD    = 2'b10,
      SEQ_RUN     = 2'b11
   } seq_state_t;

   function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
      return (hz / 1_000_000) * us;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cpurst_sync.sv
`timescale 1ns/1ps
// Reset release synchroniser: asynchronous assertion, synchronous release.
module cpurst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rel_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cpurst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
   end

   assign rel_o = chain_q[STAGES-1];

endmodule

// File: rtl/cpurst_timer.sv
`timescale 1ns/1ps
// Shared interval counter: cleared on request, saturates at the limit.
module cpurst_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         done
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (cnt_q != limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == limit);

endmodule

// File: rtl/cpurst_strap.sv
`timescale 1ns/1ps
// Strap line output stage: forced low during reset and hold, hint afterwards.
module cpurst_strap (
   input  logic force_low,
   input  logic run,
   input  logic early_ind,
   output logic strap_o,
   output logic strap_oe
);

   assign strap_o  = 1'b0;
   assign strap_oe = force_low | (run & early_ind);

endmodule

// File: rtl/cpurst_seq.sv
`timescale 1ns/1ps
module cpurst_seq
   import cpurst_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned STRETCH_US  = 1000,
   parameter int unsigned HOLD_CYC    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic early_ind,
   output logic cpu_rst_n,
   output logic strap_o,
   output logic strap_oe
);

   localparam int unsigned STRETCH_CYC = us_to_cycles(CLK_HZ, STRETCH_US);
   localparam int unsigned CNT_MAX     = max_u(STRETCH_CYC, HOLD_CYC);
   localparam int unsigned CNT_W       = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LIM_STRETCH = CNT_W'(STRETCH_CYC - 1);
   localparam logic [CNT_W-1:0] LIM_HOLD    = CNT_W'(HOLD_CYC - 1);

   if (CLK_HZ < 1_000_000) begin : g_bad_clk
      $error("cpurst_seq: CLK_HZ must be at least 1 MHz");
   end
   if (STRETCH_CYC < 4) begin : g_bad_stretch
      $error("cpurst_seq: stretch must cover at least 4 clocks of strap setup");
   end
   if ((HOLD_CYC < 2) || (HOLD_CYC > 20)) begin : g_bad_hold
      $error("cpurst_seq: HOLD_CYC must lie within 2 to 20");
   end

   logic       rel_sync;
   logic       tmr_clr;
   logic       tmr_done;
   logic [CNT_W-1:0] tmr_lim;
   seq_state_t state_q, state_nxt;

   cpurst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (sys_rst_n),
      .rel_o  (rel_sync)
   );

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         SEQ_RST:     if (rel_sync) state_nxt = SEQ_STRETCH;
         SEQ_STRETCH: if (tmr_done) state_nxt = SEQ_HOLD;
         SEQ_HOLD:    if (tmr_done) state_nxt = SEQ_RUN;
         SEQ_RUN:     state_nxt = SEQ_RUN;
         default:     state_nxt = SEQ_RST;
      endcase
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         state_q <= SEQ_RST;
      end else begin
         state_q <= state_nxt;
      end
   end

   assign tmr_clr = (state_q == SEQ_RST) || (state_nxt != state_q);
   assign tmr_lim = (state_q == SEQ_HOLD) ? LIM_HOLD : LIM_STRETCH;

   cpurst_timer #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .clr   (tmr_clr),
      .limit (tmr_lim),
      .done  (tmr_done)
   );

   assign cpu_rst_n = state_q[1];

   cpurst_strap u_strap (
      .force_low (state_q != SEQ_RUN),
      .run       (state_q == SEQ_RUN),
      .early_ind (early_ind),
      .strap_o   (strap_o),
      .strap_oe  (strap_oe)
   );

endmodule

// File: rtl/cpurst_seq_chk.sv
`timescale 1ns/1ps
module cpurst_seq_chk
   import cpurst_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned STRETCH_US  = 1000,
   parameter int unsigned HOLD_CYC    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic sys_rst_n,
   input logic early_ind,
   input logic cpu_rst_n,
   input logic strap_o,
   input logic strap_oe
);

   localparam int unsigned REL_LIM = SYNC_STAGES + 1 + us_to_cycles(CLK_HZ, STRETCH_US);

   int unsigned rel_cnt;
   int unsigned hold_cnt;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         rel_cnt <= 0;
      end else if (rel_cnt < REL_LIM) begin
         rel_cnt <= rel_cnt + 1;
      end
   end

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         hold_cnt <= 0;
      end else if (!cpu_rst_n) begin
         hold_cnt <= 0;
      end else if (hold_cnt < HOLD_CYC) begin
         hold_cnt <= hold_cnt + 1;
      end
   end

   AST_CPU_HELD_EARLY: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (rel_cnt < REL_LIM) |-> !cpu_rst_n); // R2
   AST_CPU_RELEASED_ON_TIME: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (rel_cnt >= REL_LIM) |-> cpu_rst_n); // R2
   AST_STRAP_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !cpu_rst_n |-> (strap_oe && !strap_o)); // R3
   AST_STRAP_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (cpu_rst_n && (hold_cnt < HOLD_CYC)) |-> strap_oe); // R4
   AST_STRAP_HINT_FOLLOWS: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (hold_cnt >= HOLD_CYC) |-> (strap_oe == early_ind)); // R5
   AST_EARLY_IGNORED: assert property (@(posedge clk) disable iff (!sys_rst_n)
      ((hold_cnt < HOLD_CYC) && !early_ind) |-> strap_oe); // R6
   AST_CPU_NO_FALL: assert property (@(posedge clk) disable iff (!sys_rst_n)
      cpu_rst_n |=> cpu_rst_n); // R8

endmodule

bind cpurst_seq cpurst_seq_chk #(
   .CLK_HZ      (CLK_HZ),
   .STRETCH_US  (STRETCH_US),
   .HOLD_CYC    (HOLD_CYC),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .sys_rst_n (sys_rst_n),
   .early_ind (early_ind),
   .cpu_rst_n (cpu_rst_n),
   .strap_o   (strap_o),
   .strap_oe  (strap_oe)
);

// File: tb/cpurst_seq_tb_top.sv
`timescale 1ns/1ps
module cpurst_seq_tb_top;

   localparam int unsigned P_HZ    = 50_000_000;
   localparam int unsigned P_US    = 1;
   localparam int unsigned P_HOLD  = 6;
   localparam int unsigned P_SYNC  = 2;
   localparam int          STRETCH = (P_HZ / 1_000_000) * P_US;
   localparam int          L_CPU   = P_SYNC + 1 + STRETCH;
   localparam int          L_RUN   = L_CPU + P_HOLD;

   typedef struct {
      logic  cpu;
      logic  oe;
      logic  o;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic sys_rst_n = 1'b0;
   logic early_ind = 1'b0;
   logic cpu_rst_n;
   logic strap_o;
   logic strap_oe;

   exp_t  sb_q[$];
   int    n_vec  = 0;
   int    n_fail = 0;
   int    rel    = 0;
   string pfx    = "";
   bit    done_f = 1'b0;

   always #10 clk = ~clk;

   cpurst_seq #(
      .CLK_HZ      (P_HZ),
      .STRETCH_US  (P_US),
      .HOLD_CYC    (P_HOLD),
      .SYNC_STAGES (P_SYNC)
   ) dut_i (
      .clk       (clk),
      .sys_rst_n (sys_rst_n),
      .early_ind (early_ind),
      .cpu_rst_n (cpu_rst_n),
      .strap_o   (strap_o),
      .strap_oe  (strap_oe)
   );

   // Driver: apply inputs on a falling edge, queue the outputs due after the next rising edge.
   task automatic tick(input logic rst_v, input logic early_v);
      exp_t e;
      @(negedge clk);
      sys_rst_n = rst_v;
      early_ind = early_v;
      if (!rst_v) rel = 0;
      else        rel = rel + 1;
      e.cpu = (rel >= L_CPU);
      e.oe  = (rel >= L_RUN) ? early_v : 1'b1;
      e.o   = 1'b0;
      if (rel == 0)          e.tag = "R1";
      else if (rel < L_CPU)  e.tag = early_v ? "R2 R3 R6" : "R2 R3";
      else if (rel < L_RUN)  e.tag = early_v ? "R4 R6" : "R4";
      else                   e.tag = "R5 R8";
      e.tag = {pfx, e.tag};
      sb_q.push_back(e);
   endtask

   // Asynchronous assertion: outputs must change before any clock edge.
   task automatic async_hit(input string tag);
      @(negedge clk);
      sys_rst_n = 1'b0;
      rel = 0;
      #1;
      n_vec++;
      if (cpu_rst_n !== 1'b0 || strap_oe !== 1'b1 || strap_o !== 1'b0) begin
         n_fail++;
         $display("FAIL %s async reset: cpu=%b oe=%b o=%b expected cpu=0 oe=1 o=0",
                  tag, cpu_rst_n, strap_oe, strap_o);
      end
   endtask

   // Monitor: pop and compare 5 ns after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (cpu_rst_n !== e.cpu || strap_oe !== e.oe || strap_o !== e.o) begin
               n_fail++;
               $display("FAIL %s: cpu=%b oe=%b o=%b expected cpu=%b oe=%b o=%b",
                        e.tag, cpu_rst_n, strap_oe, strap_o, e.cpu, e.oe, e.o);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_f) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state, early_ind toggling during reset
      #1;
      n_vec++;
      if (cpu_rst_n !== 1'b0 || strap_oe !== 1'b1 || strap_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 time zero: cpu=%b oe=%b o=%b expected cpu=0 oe=1 o=0",
                  cpu_rst_n, strap_oe, strap_o);
      end
      for (int i = 0; i < 5; i++) tick(1'b0, 1'(i % 2));
      // R2..R6, R8: full sequence with a varied hint pattern
      for (int i = 0; i < L_RUN + 20; i++) tick(1'b1, 1'(i % 3 == 0));
      // R7: restart from normal operation
      async_hit("R1 R7 run");
      pfx = "R7 ";
      for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
      // R7: restart in the middle of the stretch
      for (int i = 0; i < 20; i++) tick(1'b1, 1'(i % 2));
      async_hit("R7 stretch");
      for (int i = 0; i < 2; i++) tick(1'b0, 1'b0);
      for (int i = 0; i < L_CPU + 2; i++) tick(1'b1, 1'(i % 4 == 1));
      // R7: restart inside the hold window
      async_hit("R7 hold");
      tick(1'b0, 1'b1);
      for (int i = 0; i < L_RUN + 12; i++) tick(1'b1, 1'(i % 5 < 2));
      @(negedge clk);
      @(negedge clk);
      done_f = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule